// File: doc/BRIEF.md
# Multiplexed Memory Data Channel Controller

This block lets several I/O devices reach a 16-bit word memory directly, without the program moving each word. Each device owns one slot on a shared request bus. A slot presents a request line, a two-bit operation, an address and a data word. The controller grants one slot at a time and runs that slot's transfer against a single-port synchronous RAM. It then returns a one-cycle acknowledge with a result word and, for the arithmetic kinds, an overflow bit.

Requests are captured only on memory-cycle boundaries, which are marked by `cyc_start`. Service begins only when the processor signals a safe stopping point on `pause`. Once service has begun, the controller keeps granting slots until nothing is pending. This includes requests captured while earlier transfers are still running. When the queue is empty it hands control back. If a program interrupt is waiting at that moment, it raises a one-cycle pulse so the interrupt starts before normal execution resumes. The slot with the lowest index always wins. The first `HS_SLOTS` slots form the fast group and are flagged as such on their acknowledge.

Top module: `dchan_ctrl`

## Requirements
- R1: Operation code 00 (device to memory) writes the slot's data word to the slot's address. The acknowledge returns that same word on `dev_rdata`, with `dev_ovf` low.
- R2: Operation code 01 (memory to device) returns the word stored at the slot's address on `dev_rdata`, with `dev_ovf` low. Memory is left unchanged.
- R3: Operation code 10 adds one to the addressed word, and code 11 adds the slot's data word to it. The value written back and returned is the sum modulo 2^16. `dev_ovf` is high on the acknowledge exactly when the true sum exceeds 65535. The write-back always follows a read of the same word in the previous cycle.
- R4: A request line is captured only in a cycle where `cyc_start` is high. A request raised while `cyc_start` stays low is never served.
- R5: While idle, the controller starts granting only in a cycle where `pause` is high and at least one request has been captured. Otherwise `busy` stays low and no acknowledge appears.
- R6: At every grant, the lowest-numbered captured slot is chosen. This includes a slot captured during the drain, which then overtakes higher-numbered slots that are still waiting.
- R7: `ack_hs` is high during an acknowledge exactly when the acknowledged slot index is below `HS_SLOTS`. Since those slots have the lowest indices, they are served ahead of the others.
- R8: `busy` rises with the first grant and stays high until no captured request remains. A request captured in the very cycle of the last acknowledge extends the drain. Once started, the drain does not need `pause` to remain high.
- R9: `irq_go` pulses high for one cycle, in the first idle cycle after a drain ends, if and only if `irq_pend` was high in the final acknowledge cycle.
- R10: `ack` is one-hot or zero, with bit i meaning slot i, and is high for one cycle per transfer. A slot's request is not captured again in its own acknowledge cycle, so a device that drops its request right after the acknowledge is served exactly once.
- R11: During and right after reset, `busy`, `ack`, `irq_go` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Memory-cycle boundary; requests are captured when high |
| pause | input | 1 | Processor is at a point where it can yield to the channel |
| irq_pend | input | 1 | A program interrupt is waiting |
| req | input | NSLOT | Request line per slot |
| dev_op | input | 2*NSLOT | Operation code per slot (00 in, 01 out, 10 increment, 11 add) |
| dev_addr | input | AW*NSLOT | Word address per slot |
| dev_wdata | input | 16*NSLOT | Data word per slot |
| ack | output | NSLOT | One-cycle acknowledge, bit per slot |
| dev_rdata | output | 16 | Result word, valid with `ack` |
| dev_ovf | output | 1 | Arithmetic overflow, valid with `ack` |
| ack_hs | output | 1 | Acknowledged slot belongs to the fast group |
| busy | output | 1 | Channel owns memory; processor must hold |
| irq_go | output | 1 | One-cycle pulse: start the waiting interrupt |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after a read |

## Verification
Two functions can fall in one cycle: capturing a new request and the acknowledge that would otherwise end the drain. The bench provokes this by watching for a slot's acknowledge and raising a lower-numbered request in that same cycle, with `cyc_start` high and `pause` already dropped. It then requires `busy` to still be high on the next cycle. It also requires the new slot to be served next, ahead of any higher-numbered slot still waiting. A mid-drain version of the same collision checks that the late request overtakes a pending higher slot in the acknowledge order held by the scoreboard.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_IN  = 2'b00,
    OP_OUT = 2'b01,
    OP_INC = 2'b10,
    OP_ADD = 2'b11
  } xop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_RD   = 2'd2,
    ST_ACK  = 2'd3
  } xst_e;

  // Read-modify-write arithmetic: bit WORD_W of the result is the carry out.
  function automatic logic [WORD_W:0] rmw_sum(input xop_e op,
                                             input logic [WORD_W-1:0] stored,
                                             input logic [WORD_W-1:0] operand);
    logic [WORD_W-1:0] addend;
    addend = (op == OP_ADD) ? operand : WORD_W'(1);
    return {1'b0, stored} + {1'b0, addend};
  endfunction

  function automatic logic is_rmw(input xop_e op);
    return (op == OP_INC) || (op == OP_ADD);
  endfunction
endpackage

// File: rtl/dchan_sync.sv
module dchan_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_en,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_d
);
  logic [N-1:0] pend_r;
  logic [N-1:0] sampled;

  assign sampled = {N{sample_en}} & req & ~clr;
  assign pend_d  = (pend_r & ~clr) | sampled;
  assign pend_q  = pend_r;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_r <= '0;
    else        pend_r <= pend_d;
  end

  // A pending bit can only appear after a request seen on a cycle boundary.
  assert_sample_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_r & ~$past(pend_r) & ~$past(req & {N{sample_en}})) == '0);

  // A slot acknowledged in one cycle is not pending in the next.
  assert_no_double_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_r & $past(clr)) == '0);
endmodule

// File: rtl/dchan_arb.sv
module dchan_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  pend,
  output logic [IW-1:0] win_idx,
  output logic          win_any
);
  logic [N:0]   lower_any;
  logic [N-1:0] win_oh;

  assign lower_any[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign win_oh[g]      = pend[g] & ~lower_any[g];
    assign lower_any[g+1] = lower_any[g] | pend[g];
  end

  assign win_any = lower_any[N];

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (win_oh[i]) win_idx = win_idx | IW'(i);
    end
  end
endmodule

// File: rtl/dchan_ctrl.sv
module dchan_ctrl
  import dchan_pkg::*;
#(
  parameter int NSLOT    = 4,
  parameter int HS_SLOTS = 2,
  parameter int AW       = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cyc_start,
  input  logic                     pause,
  input  logic                     irq_pend,
  input  logic [NSLOT-1:0]         req,
  input  logic [2*NSLOT-1:0]       dev_op,
  input  logic [AW*NSLOT-1:0]      dev_addr,
  input  logic [WORD_W*NSLOT-1:0]  dev_wdata,
  output logic [NSLOT-1:0]         ack,
  output logic [WORD_W-1:0]        dev_rdata,
  output logic                     dev_ovf,
  output logic                     ack_hs,
  output logic                     busy,
  output logic                     irq_go,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [WORD_W-1:0]        mem_wdata,
  input  logic [WORD_W-1:0]        mem_rdata
);
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  xst_e               st_q;
  logic [IW-1:0]      gnt_q;
  xop_e               op_q;
  logic [AW-1:0]      addr_q;
  logic [WORD_W-1:0]  opnd_q;
  logic [WORD_W-1:0]  res_q;
  logic               ovf_q;
  logic               hs_q;
  logic               irq_go_q;

  logic [NSLOT-1:0]   pend_q, pend_d;
  logic [IW-1:0]      win_idx;
  logic               win_any;
  xop_e               op_w;
  logic [AW-1:0]      addr_w;
  logic [WORD_W-1:0]  opnd_w;
  logic [WORD_W:0]    sum_w;

  // Named internal events, observed by the assertions below.
  logic ev_grant, ev_rmw_wr, ev_drain_end;

  dchan_sync #(.N(NSLOT)) u_sync (
    .clk(clk), .rst_n(rst_n), .sample_en(cyc_start), .req(req),
    .clr(ack), .pend_q(pend_q), .pend_d(pend_d)
  );

  dchan_arb #(.N(NSLOT), .IW(IW)) u_arb (
    .pend(pend_q), .win_idx(win_idx), .win_any(win_any)
  );

  assign op_w   = xop_e'(dev_op[2*win_idx +: 2]);
  assign addr_w = dev_addr[AW*win_idx +: AW];
  assign opnd_w = dev_wdata[WORD_W*win_idx +: WORD_W];
  assign sum_w  = rmw_sum(op_q, mem_rdata, opnd_q);

  assign ev_grant     = (st_q == ST_SEL);
  assign ev_rmw_wr    = (st_q == ST_RD) && is_rmw(op_q);
  assign ev_drain_end = (st_q == ST_ACK) && (pend_d == '0);

  // Memory port: SEL issues the write (in) or read (others); RD writes back.
  assign mem_en    = ev_grant || ev_rmw_wr;
  assign mem_we    = (ev_grant && (op_w == OP_IN)) || ev_rmw_wr;
  assign mem_addr  = ev_grant ? addr_w : addr_q;
  assign mem_wdata = ev_grant ? opnd_w : sum_w[WORD_W-1:0];

  for (genvar g = 0; g < NSLOT; g++) begin : g_ack
    assign ack[g] = (st_q == ST_ACK) && (gnt_q == IW'(g));
  end

  assign dev_rdata = res_q;
  assign dev_ovf   = (st_q == ST_ACK) && ovf_q;
  assign ack_hs    = (st_q == ST_ACK) && hs_q;
  assign busy      = (st_q != ST_IDLE);
  assign irq_go    = irq_go_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      gnt_q    <= '0;
      op_q     <= OP_IN;
      addr_q   <= '0;
      opnd_q   <= '0;
      res_q    <= '0;
      ovf_q    <= 1'b0;
      hs_q     <= 1'b0;
      irq_go_q <= 1'b0;
    end else begin
      irq_go_q <= ev_drain_end && irq_pend;
      case (st_q)
        ST_IDLE: if (pause && (pend_q != '0)) st_q <= ST_SEL;
        ST_SEL: begin
          gnt_q  <= win_idx;
          op_q   <= op_w;
          addr_q <= addr_w;
          opnd_q <= opnd_w;
          res_q  <= opnd_w;
          ovf_q  <= 1'b0;
          hs_q   <= (32'(win_idx) < HS_SLOTS);
          st_q   <= (op_w == OP_IN) ? ST_ACK : ST_RD;
        end
        ST_RD: begin
          res_q <= (op_q == OP_OUT) ? mem_rdata : sum_w[WORD_W-1:0];
          ovf_q <= is_rmw(op_q) && sum_w[WORD_W];
          st_q  <= ST_ACK;
        end
        default: st_q <= ev_drain_end ? ST_IDLE : ST_SEL;
      endcase
    end
  end

  assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_ovf_only_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ovf |-> (ack != '0));

  assert_rmw_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rmw_wr |-> ($past(mem_en && !mem_we) && (mem_addr == $past(mem_addr))));

  assert_start_needs_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pause));

  assert_grant_has_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant |-> win_any);

  assert_drain_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pend_q == '0));

  assert_irq_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_go |-> (!busy && $past(busy)));
endmodule

// File: tb/sim_dchan_ctrl.sv
module sim_dchan_ctrl;
  localparam int NS  = 4;
  localparam int HSN = 2;
  localparam int AW  = 16;
  localparam int DW  = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cyc_start = 1'b0;
  logic               pause = 1'b0;
  logic               irq_pend = 1'b0;
  logic [NS-1:0]      req = '0;
  logic [2*NS-1:0]    dev_op = '0;
  logic [AW*NS-1:0]   dev_addr = '0;
  logic [DW*NS-1:0]   dev_wdata = '0;
  logic [NS-1:0]      ack;
  logic [DW-1:0]      dev_rdata;
  logic               dev_ovf, ack_hs, busy, irq_go;
  logic               mem_en, mem_we;
  logic [AW-1:0]      mem_addr;
  logic [DW-1:0]      mem_wdata;
  logic [DW-1:0]      mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  typedef struct {
    int          slot;
    logic [15:0] data;
    logic        ovf;
    logic        hs;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  logic [15:0] bmem [256];
  logic [15:0] ref_mem [256];

  always #2 clk = ~clk;

  dchan_ctrl #(.NSLOT(NS), .HS_SLOTS(HSN), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .pause(pause),
    .irq_pend(irq_pend), .req(req), .dev_op(dev_op), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .ack(ack), .dev_rdata(dev_rdata), .dev_ovf(dev_ovf),
    .ack_hs(ack_hs), .busy(busy), .irq_go(irq_go), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // Memory model: synchronous, one-cycle read latency.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr[7:0]];
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // Driver: compute the expected acknowledge, queue it, present the slot.
  task automatic post(input int s, input logic [1:0] op, input logic [15:0] a,
                      input logic [15:0] w, input bit raise_now);
    exp_t e;
    logic [16:0] t;
    e.slot = s;
    e.hs   = (s < HSN);
    case (op)
      2'b00: begin ref_mem[a[7:0]] = w; e.data = w; e.ovf = 1'b0; e.tag = "R1 in"; end
      2'b01: begin e.data = ref_mem[a[7:0]]; e.ovf = 1'b0; e.tag = "R2 out"; end
      2'b10: begin
        t = 17'(ref_mem[a[7:0]]) + 17'd1;
        ref_mem[a[7:0]] = t[15:0]; e.data = t[15:0]; e.ovf = t[16]; e.tag = "R3 inc";
      end
      default: begin
        t = 17'(ref_mem[a[7:0]]) + 17'(w);
        ref_mem[a[7:0]] = t[15:0]; e.data = t[15:0]; e.ovf = t[16]; e.tag = "R3 add";
      end
    endcase
    sbq.push_back(e);
    dev_op[2*s +: 2]     = op;
    dev_addr[AW*s +: AW] = a;
    dev_wdata[DW*s +: DW] = w;
    if (raise_now) req[s] = 1'b1;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (req != '0 || busy || sbq.size() != 0);
  endtask

  // Monitor: pop and compare on every acknowledge; device drops its request.
  always @(negedge clk) begin
    exp_t e;
    int idx;
    if (rst_n && ack != '0) begin
      idx = -1;
      for (int i = 0; i < NS; i++) if (ack[i]) idx = i;
      if (sbq.size() == 0) begin
        chk(1'b0, "R10 unexpected acknowledge", idx, -1);
      end else begin
        e = sbq.pop_front();
        chk(idx == e.slot, "R6 service order slot", idx, e.slot);
        chk(dev_rdata == e.data, {e.tag, " result"}, dev_rdata, e.data);
        chk(dev_ovf == e.ovf, {e.tag, " overflow"}, dev_ovf, e.ovf);
        chk(ack_hs == e.hs, "R7 fast-group flag", ack_hs, e.hs);
      end
      req = req & ~ack;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      chk(1'b0, "watchdog expired", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin bmem[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy == 1'b0, "R11 busy in reset", busy, 0);
    chk(ack == '0, "R11 ack in reset", ack, 0);
    chk(irq_go == 1'b0, "R11 irq_go in reset", irq_go, 0);
    chk(mem_en == 1'b0, "R11 mem_en in reset", mem_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy after reset", busy, 0);

    // R1: preload through the in operation, three slots at once
    cyc_start = 1'b1; pause = 1'b1;
    post(0, 2'b00, 16'd10, 16'h1234, 1'b1);
    post(2, 2'b00, 16'd11, 16'hFFFF, 1'b1);
    post(3, 2'b00, 16'd12, 16'hFFF0, 1'b1);
    wait_idle();

    // R2: read back
    post(1, 2'b01, 16'd10, 16'h0, 1'b1);
    wait_idle();

    // R3: increment and add, with and without carry
    post(0, 2'b10, 16'd13, 16'h0, 1'b1);
    post(1, 2'b10, 16'd11, 16'h0, 1'b1);
    post(2, 2'b11, 16'd12, 16'h0020, 1'b1);
    post(3, 2'b11, 16'd10, 16'h1111, 1'b1);
    wait_idle();
    // R3: wrapped values are what memory now holds
    post(1, 2'b01, 16'd11, 16'h0, 1'b1);
    post(2, 2'b01, 16'd12, 16'h0, 1'b1);
    wait_idle();

    // R4: no capture while cyc_start is low
    cyc_start = 1'b0;
    post(1, 2'b01, 16'd13, 16'h0, 1'b1);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R4 request without cycle boundary", busy, 0);
    cyc_start = 1'b1;
    wait_idle();

    // R5 / R6 / R7: captured but held off until pause, then priority order
    pause = 1'b0;
    post(0, 2'b01, 16'd10, 16'h0, 1'b1);
    post(2, 2'b01, 16'd11, 16'h0, 1'b1);
    post(3, 2'b01, 16'd13, 16'h0, 1'b1);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R5 busy without pause", busy, 0);
    chk(sbq.size() == 3, "R5 no service without pause", sbq.size(), 3);
    pause = 1'b1;
    @(negedge clk);
    pause = 1'b0;
    wait_idle();

    // R6: a late lower slot overtakes a waiting higher one
    pause = 1'b1;
    post(2, 2'b10, 16'd20, 16'h0, 1'b1);
    post(1, 2'b11, 16'd21, 16'h0005, 1'b0);
    post(3, 2'b01, 16'd10, 16'h0, 1'b1);
    do @(negedge clk); while (!ack[2]);
    req[1] = 1'b1;
    wait_idle();

    // R8: capture in the final acknowledge cycle extends the drain
    post(3, 2'b01, 16'd12, 16'h0, 1'b1);
    post(1, 2'b01, 16'd20, 16'h0, 1'b0);
    do @(negedge clk); while (!ack[3]);
    req[1] = 1'b1;
    pause = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R8 drain extended by late capture", busy, 1);
    wait_idle();
    chk(busy == 1'b0, "R8 busy low once empty", busy, 0);

    // R9: interrupt start after the drain
    pause = 1'b1; irq_pend = 1'b1;
    post(0, 2'b10, 16'd13, 16'h0, 1'b1);
    do @(negedge clk); while (!ack[0]);
    chk(irq_go == 1'b0, "R9 no pulse during acknowledge", irq_go, 0);
    @(negedge clk);
    chk(irq_go == 1'b1, "R9 pulse after drain", irq_go, 1);
    chk(busy == 1'b0, "R9 idle at pulse", busy, 0);
    @(negedge clk);
    chk(irq_go == 1'b0, "R9 pulse lasts one cycle", irq_go, 0);
    irq_pend = 1'b0;
    post(0, 2'b01, 16'd13, 16'h0, 1'b1);
    do @(negedge clk); while (!ack[0]);
    @(negedge clk);
    chk(irq_go == 1'b0, "R9 no pulse without pending interrupt", irq_go, 0);

    // R10: nothing served twice
    repeat (8) @(negedge clk);
    chk(sbq.size() == 0, "R10 scoreboard empty", sbq.size(), 0);
    chk(busy == 1'b0, "R10 no stray service", busy, 0);
    finish_run();
  end
endmodule